// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous request port and a 512K-word by 8-bit asynchronous static RAM. Each request moves one word, either a read or a write. The block turns it into a sequence of chip-select, output-enable and write-strobe levels on the memory pins. The data pins are shared, so the bus is modelled as three signals: an outgoing byte, an incoming byte and a drive enable.

Every phase of an access lasts a whole number of system clocks. At elaboration, each nanosecond limit is divided by the clock period and rounded up, with a floor of one clock. A read keeps select and output enable low until the access time has passed, then captures the incoming byte. A write keeps select and write strobe low. The write starts driving data only after the memory has had time to release the bus. It keeps driving until the data setup time has been met, and it ends the write by raising both strobes while the data is still on the bus. Between requests, select stays high so the memory can sit in its low-power state.

A new request is taken only when the controller is idle. A one-clock completion pulse marks the moment read data becomes valid or the write has ended.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, select, output enable and write strobe are high (inactive), the drive enable is low and the completion pulse is low.
- R2: Whenever no access is in progress, select, output enable and write strobe stay high and the drive enable stays low.
- R3: A read holds select and output enable low, with write strobe high, for exactly max(ceil(55 ns / T), ceil(55 ns / T)) clocks, which is 7 at T = 8 ns. The byte present on the incoming bus in the last of those clocks appears on the read data port together with the completion pulse.
- R4: During a write, output enable stays high for the whole time select and write strobe are low.
- R5: The drive enable rises only after the write strobe has been low for exactly ceil(20 ns / T) clocks, which is 3.
- R6: The data is driven for at least ceil(30 ns / T) clocks (4) before the write strobe rises. It is still driven in the first clock after the strobe rises, and the byte that was stored is the request's write data.
- R7: The write strobe low pulse lasts HZ + max(ceil(30/T), max(ceil(45/T), ceil(55/T)) − HZ) clocks, which is 7. Select is high in the clock after the strobe rises, and the address is stable while select is low.
- R8: Each accepted request produces exactly one completion pulse, one clock wide. The pulse is seen 8 clocks after a request is accepted, for both reads and writes.
- R9: A request raised while an access is in progress is ignored. It produces no completion pulse and writes nothing.
- R10: The controller never drives the data bus in a clock in which output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request, taken when idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Captured read data |
| rsp_done | output | 1 | One-clock completion pulse |
| sram_ce_n | output | 1 | Memory select, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_we_n | output | 1 | Memory write strobe, active low |
| sram_addr | output | 19 | Memory address |
| sram_dout | output | 8 | Byte driven toward the memory |
| sram_din | input | 8 | Byte read from the memory bus |
| sram_dout_en | output | 1 | Controller drives the bus when high |

## Verification
Two events can fall in the same clock: the completion pulse of one access and the acceptance of the next request. The bench provokes this by holding the request high across consecutive accesses and changing the payload in the clock the pulse appears. A read is accepted on the very next edge, so completions come 8 clocks apart. After a write, the release clock comes first, so completions come 9 clocks apart. A separate scenario raises a request in the middle of a write. Its address is then read back to show that nothing was stored, and the bench confirms no extra completion pulse appeared.

// File: rtl/sram_bus_pkg.sv
package sram_bus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_WR_HZ,
        ST_WR_DAT,
        ST_WR_END
    } state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic dout_en;
    } pins_t;

    // Clocks needed to cover a nanosecond limit, never fewer than one.
    function automatic int ns_to_clk(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Pin levels belonging to each state.
    function automatic pins_t pins_for(input state_e s);
        pins_t p;
        case (s)
            ST_RD:     p = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, dout_en: 1'b0};
            ST_WR_HZ:  p = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, dout_en: 1'b0};
            ST_WR_DAT: p = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, dout_en: 1'b1};
            ST_WR_END: p = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dout_en: 1'b1};
            default:   p = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dout_en: 1'b0};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] held
);

    logic [DATA_W-1:0] held_d, held_q;

    always_comb begin
        held_d = cap ? bus_in : held_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) held_q <= '0;
        else        held_q <= held_d;
    end

    assign held = held_q;

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
    import sram_bus_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int DATA_W    = 8,
    parameter int CLK_NS    = 8,
    parameter int T_AA_NS   = 55,
    parameter int T_RC_NS   = 55,
    parameter int T_WC_NS   = 55,
    parameter int T_PWE_NS  = 45,
    parameter int T_AW_NS   = 45,
    parameter int T_SD_NS   = 30,
    parameter int T_HZWE_NS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dout,
    input  logic [DATA_W-1:0] sram_din,
    output logic              sram_dout_en
);

    localparam int RD_CLKS  = imax(ns_to_clk(T_AA_NS, CLK_NS), ns_to_clk(T_RC_NS, CLK_NS));
    localparam int HZ_CLKS  = ns_to_clk(T_HZWE_NS, CLK_NS);
    localparam int WE_CLKS  = imax(imax(ns_to_clk(T_PWE_NS, CLK_NS), ns_to_clk(T_AW_NS, CLK_NS)),
                                   ns_to_clk(T_WC_NS, CLK_NS));
    localparam int DAT_CLKS = imax(imax(ns_to_clk(T_SD_NS, CLK_NS), WE_CLKS - HZ_CLKS), 1);
    localparam int MAX_CLKS = imax(RD_CLKS, imax(HZ_CLKS, DAT_CLKS));
    localparam int CNT_W    = $clog2(MAX_CLKS + 1);

    typedef struct packed {
        state_e            st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              done;
        pins_t             pins;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_IDLE, addr: '0, wdata: '0, done: 1'b0,
                                 pins: '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dout_en: 1'b0}};

    ctl_t             ctl_d, ctl_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             cap;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap    (cap),
        .bus_in (sram_din),
        .held   (rsp_rdata)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        cap        = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (req) begin
                    ctl_d.addr  = req_addr;
                    ctl_d.wdata = req_wdata;
                    tmr_load    = 1'b1;
                    if (req_wr) begin
                        ctl_d.st = ST_WR_HZ;
                        tmr_val  = CNT_W'(HZ_CLKS - 1);
                    end else begin
                        ctl_d.st = ST_RD;
                        tmr_val  = CNT_W'(RD_CLKS - 1);
                    end
                end
            end
            ST_RD: begin
                if (tmr_expired) begin
                    cap        = 1'b1;
                    ctl_d.done = 1'b1;
                    ctl_d.st   = ST_IDLE;
                end
            end
            ST_WR_HZ: begin
                if (tmr_expired) begin
                    ctl_d.st = ST_WR_DAT;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(DAT_CLKS - 1);
                end
            end
            ST_WR_DAT: begin
                if (tmr_expired) begin
                    ctl_d.done = 1'b1;
                    ctl_d.st   = ST_WR_END;
                end
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
        ctl_d.pins = pins_for(ctl_d.st);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign rsp_done     = ctl_q.done;
    assign sram_ce_n    = ctl_q.pins.ce_n;
    assign sram_oe_n    = ctl_q.pins.oe_n;
    assign sram_we_n    = ctl_q.pins.we_n;
    assign sram_dout_en = ctl_q.pins.dout_en;
    assign sram_addr    = ctl_q.addr;
    assign sram_dout    = ctl_q.wdata;

    assert_no_contention_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dout_en |-> sram_oe_n);

    assert_oe_off_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> sram_oe_n);

    assert_drive_after_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dout_en) |-> (!sram_we_n && !$past(sram_we_n)));

    assert_data_held_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sram_we_n) && !$past(sram_ce_n)) |-> sram_dout_en);

    assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && !$past(sram_ce_n)) |-> $stable(sram_addr));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

endmodule

// File: tb/sram_bus_ctrl_test.sv
module sram_bus_ctrl_test;

    localparam int T   = 8;
    localparam int E_RD = ((55 + T - 1) / T);
    localparam int E_HZ = ((20 + T - 1) / T);
    localparam int E_SD = ((30 + T - 1) / T);
    localparam int E_WC = ((55 + T - 1) / T);
    localparam int E_WE = E_HZ + ((E_SD > E_WC - E_HZ) ? E_SD : E_WC - E_HZ);
    localparam int E_LAT = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_wr = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  rsp_rdata;
    logic        rsp_done;
    logic        sram_ce_n, sram_oe_n, sram_we_n, sram_dout_en;
    logic [18:0] sram_addr;
    logic [7:0]  sram_dout, sram_din;

    int n_chk = 0;
    int n_bad = 0;
    int contention = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    sram_bus_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .rsp_done(rsp_done), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_addr(sram_addr), .sram_dout(sram_dout),
        .sram_din(sram_din), .sram_dout_en(sram_dout_en)
    );

    // Clocked memory model on a folded index: address bits 18:16 and 4:0.
    function automatic logic [7:0] idx(input logic [18:0] a);
        return {a[18:16], a[4:0]};
    endfunction

    logic [7:0]  mem [256];
    logic [7:0]  shadow [256];
    logic        pend;
    logic [18:0] pend_a;
    logic [7:0]  pend_d;
    int          rd_cnt;
    logic        mem_drive;
    logic [7:0]  mem_dq;

    assign mem_drive = !sram_ce_n && !sram_oe_n && sram_we_n;
    assign mem_dq    = (rd_cnt >= E_RD - 1) ? mem[idx(sram_addr)] : 8'hEE;
    assign sram_din  = mem_drive ? mem_dq : (sram_dout_en ? sram_dout : 8'hA5);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend   <= 1'b0;
            pend_a <= '0;
            pend_d <= '0;
            rd_cnt <= 0;
            for (int i = 0; i < 256; i++) mem[i] <= '0;
        end else begin
            if (!sram_ce_n && !sram_we_n) begin
                pend   <= 1'b1;
                pend_a <= sram_addr;
                pend_d <= sram_dout_en ? sram_dout : 8'hA5;
            end else if (pend) begin
                mem[idx(pend_a)] <= pend_d;
                pend             <= 1'b0;
            end
            rd_cnt <= mem_drive ? rd_cnt + 1 : 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Pin monitor, sampled at the falling edge.
    int we_run = 0, dat_run = 0, rd_run = 0;
    bit en_prev = 1'b0;
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            we_run = 0; dat_run = 0; rd_run = 0; en_prev = 1'b0;
        end else begin
            if (sram_dout_en && mem_drive) contention++;
            if (!sram_we_n) begin
                if (sram_dout_en && !en_prev) begin
                    chk(we_run == E_HZ, "R5 strobe-low clocks before drive", we_run, E_HZ);
                    chk(sram_oe_n && !sram_ce_n, "R4 oe high in write", sram_oe_n, 1);
                end
                we_run++;
                if (sram_dout_en) dat_run++;
            end else if (we_run != 0) begin
                chk(we_run == E_WE, "R7 strobe low width", we_run, E_WE);
                chk(sram_ce_n, "R7 select high after write", sram_ce_n, 1);
                chk(dat_run >= E_SD, "R6 data setup clocks", dat_run, E_SD);
                chk(sram_dout_en, "R6 data held past strobe", sram_dout_en, 1);
                we_run = 0; dat_run = 0;
            end
            if (!sram_oe_n) rd_run++;
            else if (rd_run != 0) begin
                chk(rd_run == E_RD, "R3 read strobe width", rd_run, E_RD);
                rd_run = 0;
            end
            en_prev = sram_dout_en;
        end
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(negedge clk) begin
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            finish_run();
        end
    end

    task automatic issue(input bit wr, input logic [18:0] a, input logic [7:0] d);
        @(negedge clk);
        req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    endtask

    task automatic wait_done(input bit drop, output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
            if (drop) req = 1'b0;
        end while (!rsp_done && k < 40);
    endtask

    task automatic check_idle(input string where);
        chk(sram_ce_n && sram_oe_n && sram_we_n && !sram_dout_en,
            {"R2 idle pins ", where}, {sram_ce_n, sram_oe_n, sram_we_n, sram_dout_en}, 4'b1110);
    endtask

    task automatic test_reset();
        chk(sram_ce_n && sram_oe_n && sram_we_n && !sram_dout_en && !rsp_done,
            "R1 pins in reset", {sram_ce_n, sram_oe_n, sram_we_n, sram_dout_en, rsp_done}, 5'b11100);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(sram_ce_n && sram_oe_n && sram_we_n && !sram_dout_en && !rsp_done,
            "R1 pins after reset", {sram_ce_n, sram_oe_n, sram_we_n, sram_dout_en, rsp_done}, 5'b11100);
    endtask

    task automatic do_write(input logic [18:0] a, input logic [7:0] d);
        int k;
        issue(1'b1, a, d);
        wait_done(1'b1, k);
        shadow[idx(a)] = d;
        chk(k == E_LAT, "R8 write completion latency", k, E_LAT);
        @(negedge clk);
        chk(!rsp_done, "R8 write pulse one clock", rsp_done, 0);
        @(negedge clk);
        check_idle("after write");
    endtask

    task automatic do_read(input logic [18:0] a, input string tag);
        int k;
        issue(1'b0, a, 8'h00);
        wait_done(1'b1, k);
        chk(k == E_LAT, "R8 read completion latency", k, E_LAT);
        chk(rsp_rdata == shadow[idx(a)], tag, rsp_rdata, shadow[idx(a)]);
        @(negedge clk);
        chk(!rsp_done, "R8 read pulse one clock", rsp_done, 0);
        check_idle("after read");
    endtask

    task automatic test_single();
        do_write(19'h12345, 8'h3C);
        do_read(19'h12345, "R6 readback 12345");
        do_write(19'h4001A, 8'hC3);
        do_read(19'h4001A, "R3 readback 4001A");
        do_read(19'h12345, "R3 readback 12345 again");
    endtask

    task automatic test_boundary();
        do_write(19'h00000, 8'h01);
        do_write(19'h7FFFF, 8'hFE);
        do_read(19'h00000, "R3 lowest address");
        do_read(19'h7FFFF, "R3 highest address");
    endtask

    task automatic test_back_to_back();
        int k;
        issue(1'b1, 19'h2000C, 8'h5A);
        wait_done(1'b0, k);
        shadow[idx(19'h2000C)] = 8'h5A;
        chk(k == E_LAT, "R8 first chained write", k, E_LAT);
        req_addr = 19'h2000D; req_wdata = 8'h69;
        wait_done(1'b0, k);
        shadow[idx(19'h2000D)] = 8'h69;
        chk(k == E_LAT + 1, "R8 chained write spacing", k, E_LAT + 1);
        req_wr = 1'b0; req_addr = 19'h2000C;
        wait_done(1'b0, k);
        chk(k == E_LAT + 1, "R8 read after chained write", k, E_LAT + 1);
        chk(rsp_rdata == 8'h5A, "R3 chained read 2000C", rsp_rdata, 8'h5A);
        req_addr = 19'h2000D;
        wait_done(1'b0, k);
        req = 1'b0;
        chk(k == E_LAT, "R8 chained read spacing", k, E_LAT);
        chk(rsp_rdata == 8'h69, "R3 chained read 2000D", rsp_rdata, 8'h69);
        @(negedge clk);
        check_idle("after chain");
    endtask

    task automatic test_busy_ignore();
        int k, extra;
        issue(1'b1, 19'h30011, 8'h77);
        @(negedge clk); req = 1'b0;
        @(negedge clk);
        req = 1'b1; req_wr = 1'b1; req_addr = 19'h60002; req_wdata = 8'h99;
        @(negedge clk); req = 1'b0;
        k = 3;
        while (!rsp_done && k < 40) begin @(negedge clk); k++; end
        shadow[idx(19'h30011)] = 8'h77;
        chk(k == E_LAT, "R9 first write unaffected", k, E_LAT);
        extra = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (rsp_done) extra++;
        end
        chk(extra == 0, "R9 no pulse for ignored request", extra, 0);
        do_read(19'h60002, "R9 ignored write stored nothing");
        do_read(19'h30011, "R9 accepted write stored");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) shadow[i] = 8'h00;
        repeat (3) @(negedge clk);
        test_reset();
        test_single();
        test_boundary();
        test_back_to_back();
        test_busy_ignore();
        chk(contention == 0, "R10 bus contention clocks", contention, 0);
        repeat (4) @(negedge clk);
        check_idle("at end");
        finish_run();
    end

endmodule